// File: doc/BRIEF.md
# Serial LED Status Frame Transmitter

This block holds a packed LED pattern for a group of drive ports and pushes it out to an external LED controller over three wires: a serial clock, a load strobe and a data line. A host-side agent hands it one update at a time: a port number and a 32-bit status word. From that word the block takes three indicator flags: activity, locate and fault. It writes them into the three pattern bits of the slot that a per-port remap table assigns to the port. It then transmits one frame built from the updated pattern.

A frame has four parts, sent in this order. First come a configurable number of idle leading clocks. Next is a single clock cycle during which load is high. Then come three data bits per active port, lowest pattern bit first, with one bit per clock cycle. Last come a configurable number of idle trailing clocks. Each clock cycle spends a parameterised number of core cycles high and the same number low. The nominal half period is 50 microseconds. The block accepts no new update while a frame is being sent, and it pulses a completion flag when the last trailing clock ends. The status word also carries a slot index field. An update whose index is out of range is refused with an error pulse.

Top module: `led_frame_tx`

## Requirements
- R1: The flags are decoded from the status word as follows. Activity is bit 21 OR bit 20, locate is bit 19 and fault is bit 22. They are written to pattern bits 3*s+0, 3*s+1 and 3*s+2, where s is the slot that `cfg_map_i[3*p +: 3]` gives for request port p.
- R2: An accepted update overwrites all three flag bits of its slot, so a flag whose status bits are all clear is cleared. Bits of every other slot keep their values.
- R3: A request whose status bits [15:8] are not below PM_SLOTS is refused. The block raises `req_err_o` for one cycle after the request is taken, sends no frame and leaves the pattern unchanged.
- R4: A frame starts with `cfg_pre_i` clock cycles with load low. Exactly one clock cycle follows with `sload_o` high, and load is low again from the next cycle on.
- R5: After the load cycle, 3*min(`cfg_nports_i`, NUM_PORTS) data bits follow, pattern bit 0 first, one per clock cycle. Each bit holds steady on `sdata_o` for the whole high phase of its clock.
- R6: After the data bits come `cfg_post_i` clock cycles. Then `done_o` is high for exactly one cycle, at the end of the last low phase, and `sclk_o` and `sload_o` are then low.
- R7: Within a frame, every serial clock cycle is HALF_CYC core cycles high followed by HALF_CYC core cycles low. Between frames `sclk_o` does not change.
- R8: After reset `sclk_o`, `sload_o` and `sdata_o` are high, `req_ready_o` is high, `done_o` is low and every pattern bit is zero.
- R9: `req_ready_o` is low from the cycle after an accepted update until the frame ends. A request presented during that time has no effect on the pattern.
- R10: With zero leading and trailing counts, the frame consists of the load cycle and the data bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Update request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_port_i | input | PORT_W | Port the update belongs to |
| req_status_i | input | 32 | Status word carrying flags and slot index |
| req_err_o | output | 1 | One-cycle pulse for a refused request |
| cfg_pre_i | input | CLK_W | Leading clock count |
| cfg_post_i | input | CLK_W | Trailing clock count |
| cfg_nports_i | input | NP_W | Number of ports shifted out |
| cfg_map_i | input | NUM_PORTS*SLOT_W | Port-to-slot remap table, entry p at [SLOT_W*p +: SLOT_W] |
| sclk_o | output | 1 | Serial clock line |
| sload_o | output | 1 | Load strobe line |
| sdata_o | output | 1 | Serial data line |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
The bench uses a reverse remap table and later switches to an identity table. A design that ignored the table, or that counted slots as whole ports, would put flags in the wrong data positions. It sends a status word with no flag bits set but with neighbouring bits set, to catch a decoder that keeps stale flags or reads the wrong bits. It also presents refused slot indices and requests made while a frame is in flight: a leaky design would show those changes in the next frame's data. Zero leading and trailing counts, a port count above the limit and a port count of zero test the frame-length arithmetic, which an off-by-one design gets wrong by one clock cycle.

// File: rtl/led_frame_pkg.sv
package led_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LOAD,
    ST_DATA,
    ST_POST
  } fr_state_e;

  localparam int unsigned ACT_LO_BIT = 20;
  localparam int unsigned ACT_HI_BIT = 21;
  localparam int unsigned LOC_BIT    = 19;
  localparam int unsigned FLT_BIT    = 22;
  localparam int unsigned SLOTF_LO   = 8;
  localparam int unsigned SLOTF_HI   = 15;

  // {fault, locate, activity}
  function automatic logic [2:0] led_flags(input logic [31:0] st);
    return {st[FLT_BIT], st[LOC_BIT], st[ACT_HI_BIT] | st[ACT_LO_BIT]};
  endfunction

endpackage

// File: rtl/led_pat_store.sv
module led_pat_store #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned SLOT_W    = 3,
  parameter int unsigned PORT_W    = 3,
  localparam int unsigned PAT_W    = 3 * NUM_PORTS
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [PORT_W-1:0]             port_i,
  input  logic [31:0]                   status_i,
  input  logic [NUM_PORTS*SLOT_W-1:0]   map_i,
  output logic [PAT_W-1:0]              pat_next_o
);
  import led_frame_pkg::*;

  logic [PAT_W-1:0]  pat_q;
  logic [SLOT_W-1:0] slot;
  logic [2:0]        flags;

  assign flags = led_flags(status_i);

  always_comb begin
    slot = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_i == PORT_W'(p)) slot = map_i[p*SLOT_W +: SLOT_W];
    end
  end

  always_comb begin
    pat_next_o = pat_q;
    for (int s = 0; s < NUM_PORTS; s++) begin
      if (slot == SLOT_W'(s)) pat_next_o[3*s +: 3] = flags;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pat_q <= '0;
    else if (wr_i) pat_q <= pat_next_o;
  end

endmodule

// File: rtl/led_bit_timer.sv
module led_bit_timer #(
  parameter int unsigned HALF_CYC = 2500,
  localparam int unsigned CW = ($clog2(2 * HALF_CYC) < 1) ? 1 : $clog2(2 * HALF_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic half_o,
  output logic end_o
);
  logic [CW-1:0] cnt_q;

  assign half_o = run_i && (cnt_q == CW'(HALF_CYC - 1));
  assign end_o  = run_i && (cnt_q == CW'(2 * HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || end_o)  cnt_q <= '0;
    else if (run_i)           cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned CLK_W     = 4,
  parameter int unsigned NP_W      = 4,
  localparam int unsigned PAT_W    = 3 * NUM_PORTS,
  localparam int unsigned BIT_W    = $clog2(PAT_W + 1),
  localparam int unsigned CNT_W    = (CLK_W > BIT_W) ? CLK_W : BIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [CLK_W-1:0] pre_i,
  input  logic [CLK_W-1:0] post_i,
  input  logic [NP_W-1:0]  nports_i,
  input  logic             half_i,
  input  logic             end_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             sload_o,
  output logic             sdata_o,
  output logic             done_o
);
  import led_frame_pkg::*;

  fr_state_e        st_q, adv_st;
  logic [CNT_W-1:0] cnt_q, adv_cnt;
  logic [CNT_W-1:0] nbits_q, post_q, nbits_live;
  logic [NP_W-1:0]  nports_c;
  logic [PAT_W-1:0] sh_q;

  assign nports_c   = (nports_i > NP_W'(NUM_PORTS)) ? NP_W'(NUM_PORTS) : nports_i;
  assign nbits_live = CNT_W'(nports_c) * CNT_W'(3);
  assign busy_o     = (st_q != ST_IDLE);

  // phase that follows the current one (from idle: first phase of a frame)
  always_comb begin
    adv_st  = ST_IDLE;
    adv_cnt = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (pre_i != '0) begin adv_st = ST_PRE;  adv_cnt = CNT_W'(pre_i); end
        else             begin adv_st = ST_LOAD; adv_cnt = CNT_W'(1);     end
      end
      ST_PRE: begin adv_st = ST_LOAD; adv_cnt = CNT_W'(1); end
      ST_LOAD: begin
        if (nbits_q != '0)     begin adv_st = ST_DATA; adv_cnt = nbits_q; end
        else if (post_q != '0) begin adv_st = ST_POST; adv_cnt = post_q;  end
      end
      ST_DATA: begin
        if (post_q != '0) begin adv_st = ST_POST; adv_cnt = post_q; end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      nbits_q <= '0;
      post_q  <= '0;
      sh_q    <= '0;
      sclk_o  <= 1'b1;
      sload_o <= 1'b1;
      sdata_o <= 1'b1;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          st_q    <= adv_st;
          cnt_q   <= adv_cnt;
          sclk_o  <= 1'b1;
          sload_o <= (adv_st == ST_LOAD);
          sh_q    <= pat_i;
          nbits_q <= nbits_live;
          post_q  <= CNT_W'(post_i);
        end
      end else begin
        if (half_i) sclk_o <= 1'b0;
        if (end_i) begin
          if (cnt_q > CNT_W'(1)) begin
            cnt_q  <= cnt_q - CNT_W'(1);
            sclk_o <= 1'b1;
            if (st_q == ST_DATA) begin
              sdata_o <= sh_q[0];
              sh_q    <= sh_q >> 1;
            end
          end else begin
            st_q    <= adv_st;
            cnt_q   <= adv_cnt;
            sload_o <= (adv_st == ST_LOAD);
            if (adv_st == ST_IDLE) done_o <= 1'b1;
            else                   sclk_o <= 1'b1;
            if (adv_st == ST_DATA) begin
              sdata_o <= sh_q[0];
              sh_q    <= sh_q >> 1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/led_frame_tx.sv
module led_frame_tx #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned PM_SLOTS  = 8,
  parameter int unsigned HALF_CYC  = 2500,
  parameter int unsigned CLK_W     = 4,
  localparam int unsigned SLOT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned PORT_W   = SLOT_W,
  localparam int unsigned NP_W     = $clog2(NUM_PORTS + 1),
  localparam int unsigned PAT_W    = 3 * NUM_PORTS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [PORT_W-1:0]           req_port_i,
  input  logic [31:0]                 req_status_i,
  output logic                        req_err_o,
  input  logic [CLK_W-1:0]            cfg_pre_i,
  input  logic [CLK_W-1:0]            cfg_post_i,
  input  logic [NP_W-1:0]             cfg_nports_i,
  input  logic [NUM_PORTS*SLOT_W-1:0] cfg_map_i,
  output logic                        sclk_o,
  output logic                        sload_o,
  output logic                        sdata_o,
  output logic                        done_o
);
  import led_frame_pkg::*;

  logic             busy, accept, slot_ok, start;
  logic             half, bit_end;
  logic [PAT_W-1:0] pat_next;

  assign slot_ok     = {24'd0, req_status_i[SLOTF_HI:SLOTF_LO]} < 32'(PM_SLOTS);
  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;
  assign start       = accept && slot_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_err_o <= 1'b0;
    else         req_err_o <= accept && !slot_ok;
  end

  led_pat_store #(
    .NUM_PORTS(NUM_PORTS), .SLOT_W(SLOT_W), .PORT_W(PORT_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (start),
    .port_i     (req_port_i),
    .status_i   (req_status_i),
    .map_i      (cfg_map_i),
    .pat_next_o (pat_next)
  );

  led_bit_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .clr_i  (start),
    .half_o (half),
    .end_o  (bit_end)
  );

  led_frame_seq #(
    .NUM_PORTS(NUM_PORTS), .CLK_W(CLK_W), .NP_W(NP_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .pat_i    (pat_next),
    .pre_i    (cfg_pre_i),
    .post_i   (cfg_post_i),
    .nports_i (cfg_nports_i),
    .half_i   (half),
    .end_i    (bit_end),
    .busy_o   (busy),
    .sclk_o   (sclk_o),
    .sload_o  (sload_o),
    .sdata_o  (sdata_o),
    .done_o   (done_o)
  );

endmodule

// File: rtl/led_frame_tx_chk.sv
module led_frame_tx_chk #(
  parameter int unsigned PM_SLOTS = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [7:0] req_slot_i,
  input logic       req_err_o,
  input logic       sclk_o,
  input logic       sload_o,
  input logic       sdata_o,
  input logic       done_o
);

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);                                              // R6

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                                  // R6

  AST_ERR_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> req_ready_o);                                           // R3

  AST_LOAD_FALL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sload_o) |-> !req_ready_o);                                     // R4

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && ({24'd0, req_slot_i} < 32'(PM_SLOTS))) |=> !req_ready_o); // R9

  AST_IDLE_SCLK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && $past(req_ready_o)) |-> $stable(sclk_o));             // R7

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !$past(req_ready_o) && sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R5

endmodule

bind led_frame_tx led_frame_tx_chk #(.PM_SLOTS(PM_SLOTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_slot_i  (req_status_i[15:8]),
  .req_err_o   (req_err_o),
  .sclk_o      (sclk_o),
  .sload_o     (sload_o),
  .sdata_o     (sdata_o),
  .done_o      (done_o)
);

// File: tb/led_frame_tx_bench.sv
`timescale 1ns/1ps
module led_frame_tx_bench;
  localparam int NP = 8, HALF = 3, PMS = 8, CW = 4, SW = 3, NPW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0, req_ready, req_err;
  logic [SW-1:0] req_port = '0;
  logic [31:0]   req_status = '0;
  logic [CW-1:0] cfg_pre = 4'd2, cfg_post = 4'd3;
  logic [NPW-1:0] cfg_nports = 4'd8;
  logic [NP*SW-1:0] cfg_map;
  logic          sclk, sload, sdata, done;
  logic [2:0]    map_m [NP];

  always_comb for (int p = 0; p < NP; p++) cfg_map[p*SW +: SW] = map_m[p];

  led_frame_tx #(.NUM_PORTS(NP), .PM_SLOTS(PMS), .HALF_CYC(HALF), .CLK_W(CW)) u_led_frame_tx (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_port_i(req_port), .req_status_i(req_status), .req_err_o(req_err),
    .cfg_pre_i(cfg_pre), .cfg_post_i(cfg_post), .cfg_nports_i(cfg_nports), .cfg_map_i(cfg_map),
    .sclk_o(sclk), .sload_o(sload), .sdata_o(sdata), .done_o(done)
  );

  typedef struct {
    int          pre, post, nbits;
    logic [31:0] pat;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0, errors = 0, done_cnt = 0;
  logic [23:0] mpat = '0;
  bit          finished = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: issues one request, pushes the expected frame
  task automatic send(int p, logic [31:0] st, string tag);
    exp_t e;
    int   n;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_port = SW'(p); req_status = st;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (st[15:8] >= PMS) begin
      chk(req_err == 1'b1, "R3", "error pulse", 32'(req_err), 1);
    end else begin
      mpat[3*map_m[p] +: 3] = {st[22], st[19], st[21] | st[20]};
      n = (cfg_nports > NP) ? NP : int'(cfg_nports);
      e.pre = cfg_pre; e.post = cfg_post; e.nbits = 3 * n;
      e.pat = {8'd0, mpat}; e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  logic        prev_sclk = 1'b1;
  int          hi_run = 0, lo_run = 0, ncyc = 0, ldcnt = 0, ldpos = -1;
  logic [31:0] gotv = '0;
  bit          tbad = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_sclk && !sclk) begin
        if (hi_run != HALF) tbad = 1;
        hi_run = 0;
        if (sload) begin ldcnt++; ldpos = ncyc; end
        else if (ldcnt > 0 && (ncyc - ldpos - 1) < 32) gotv[ncyc - ldpos - 1] = sdata;
        ncyc++;
      end
      if (!prev_sclk && sclk && lo_run != 0) begin
        if (lo_run != HALF) tbad = 1;
        lo_run = 0;
      end
      if (done) begin
        exp_t        e;
        logic [31:0] mask;
        done_cnt++;
        if (lo_run != HALF) tbad = 1;
        lo_run = 0;
        if (sb_q.size() == 0) begin
          chk(0, "R9", "unexpected frame", 32'(ncyc), 0);
        end else begin
          e = sb_q.pop_front();
          chk(ncyc == e.pre + 1 + e.nbits + e.post, "R4", "clock cycles in frame",
              32'(ncyc), 32'(e.pre + 1 + e.nbits + e.post));
          chk(ldcnt == 1 && ldpos == e.pre, "R4", "load cycle position",
              32'(ldpos), 32'(e.pre));
          mask = (e.nbits >= 32) ? '1 : ((32'd1 << e.nbits) - 32'd1);
          chk((gotv & mask) == (e.pat & mask), {e.tag, "/R5"}, "data bits",
              gotv & mask, e.pat & mask);
          chk(!tbad, "R7", "half period width", 32'(tbad), 0);
          chk(!sclk && !sload, "R6", "lines after frame", {30'd0, sclk, sload}, 0);
          if (e.pre == 0 && e.post == 0)
            chk(ncyc == 1 + e.nbits, "R10", "frame without idle clocks",
                32'(ncyc), 32'(1 + e.nbits));
        end
        ncyc = 0; ldcnt = 0; ldpos = -1; gotv = '0; tbad = 0;
      end
      if (!req_ready) begin
        if (sclk) hi_run++;
        else      lo_run++;
      end
    end
    prev_sclk = sclk;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int dc;
    bit ready_low;
    for (int p = 0; p < NP; p++) map_m[p] = 3'(NP - 1 - p);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(sclk && sload && sdata, "R8", "lines after reset", {29'd0, sclk, sload, sdata}, 7);
    chk(req_ready && !done && !req_err, "R8", "ready/done after reset",
        {29'd0, req_ready, done, req_err}, 4);

    send(0, 32'h0, "R8");
    send(1, 32'h0010_0000, "R1");
    send(2, 32'h0020_0000, "R1");
    send(3, 32'h0008_0000, "R1");
    send(4, 32'h0040_0000, "R1");
    send(5, 32'h0078_0000, "R1");
    send(5, 32'hFF87_00FF, "R2");
    send(1, 32'h0, "R2");
    drain();

    dc = done_cnt;
    send(6, 32'h0040_0800, "R3");
    send(6, 32'h0040_FF00, "R3");
    repeat (20) @(negedge clk);
    chk(done_cnt == dc && req_ready, "R3", "no frame after refusal", 32'(done_cnt), 32'(dc));
    send(0, 32'h0, "R3");
    drain();

    send(7, 32'h0008_0000, "R9");
    repeat (4) @(negedge clk);
    ready_low = 1;
    req_valid = 1'b1; req_port = 3'd6; req_status = 32'h0040_0000;
    repeat (4) begin
      @(negedge clk);
      if (req_ready) ready_low = 0;
    end
    req_valid = 1'b0;
    chk(ready_low, "R9", "ready low while busy", 32'(ready_low), 1);
    drain();
    send(0, 32'h0, "R9");
    drain();

    cfg_pre = '0; cfg_post = '0; cfg_nports = 4'd3;
    send(7, 32'h0040_0000, "R10");
    drain();

    cfg_pre = 4'd1; cfg_post = 4'd1; cfg_nports = 4'd15;
    send(4, 32'h0020_0000, "R5");
    drain();
    cfg_nports = 4'd0;
    send(3, 32'h0, "R5");
    drain();

    for (int p = 0; p < NP; p++) map_m[p] = 3'(p);
    cfg_nports = 4'd8; cfg_pre = 4'd1; cfg_post = 4'd2;
    @(negedge clk);
    send(7, 32'h0010_0000, "R1");
    send(2, 32'h0048_0000, "R1");
    drain();
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule